// File: doc/BRIEF.md
# Multicast Globule Write-Back Router

This block sits at the write-back end of a clustered register file. The file is split into four globules of sixteen registers each. Up to four issue slots share it. For every slot the router forms two operand read addresses. One is the slot's 6-bit full source address. The other joins that address's globule field with a 4-bit partial index, so the second operand always comes from the same globule. That globule is the slot's home globule.

A result names its destination with a 3-bit globule code and a 4-bit register index. The code is read relative to the slot's home globule. It expands to a 4-bit target mask that selects one globule, a pair of globules, or all four. The masks of all slots are decoded in parallel, and hazard handling works only on these decoded bits.

A bundle of slot results enters through a valid/ready handshake. The router removes write-after-write duplicates. It then grants at most one write per globule per cycle, taking lower slots first, and sends each grant to that globule's write port. A write to the home globule lands one cycle after it is granted. A write to any other globule takes one extra register stage. The write ports apply no back-pressure. Instead, the router holds `in_ready` low while any write of the current bundle has not yet been granted.

Top module: `gwb_router`

## Requirements
- R1: `rd_a` of each slot equals its `src_full`. `rd_b` equals `{src_full[5:4], src_part}`. Both are combinational.
- R2: Globule codes 0 to 3 (bit 2 clear) write only globule 0, 1, 2 or 3 respectively, whatever the home globule is.
- R3: Codes 4, 5 and 6 write the home globule h and globule (h+1), (h+2) or (h+3) modulo 4 respectively.
- R4: Code 7 writes the same register index in all four globules.
- R5: When a bundle is accepted on rising edge k, a write to the slot's home globule is present on that globule's write port between edges k+1 and k+2. Nothing is written between edges k and k+1.
- R6: A write to a globule other than the slot's home globule appears exactly one cycle later than R5, between edges k+2 and k+3.
- R7: Two enabled slots of one bundle may target the same register in the same globule. The higher-numbered slot's data is written there and the lower slot's write to that globule is dropped. Bit g of `waw_flag` is high between edges k and k+1 for each globule g where this happened.
- R8: Each globule receives at most one write per cycle. Slots that target one globule with different registers are written in ascending slot order, in consecutive cycles when there is no other obstruction.
- R9: At most WPORTS globule writes are granted per cycle. Grants beyond the limit are taken in ascending globule order. With WPORTS=1, a bundle that broadcasts from a single slot keeps `busy` high for exactly 4 cycles after the accepting edge. Its writes arrive at globule 0 before globule 1, and at globule 1 before globule 3 (home globule 2).
- R10: A bundle is taken only on a rising edge with `in_valid && in_ready`. `in_ready` is high exactly when `busy` is low. `busy` is high while any granted-pending write of the accepted bundle remains. After reset `in_ready`=1, `busy`=0, `wr_en`=0 and `waw_flag`=0.
- R11: A slot whose `slot_vld` bit is 0 writes nothing. A bundle with no enabled slot leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Router can take a bundle |
| slot_vld | input | SLOTS | Per-slot enable |
| src_full | input | SLOTS x 6 | Full source address; bits 5:4 give the home globule |
| src_part | input | SLOTS x 4 | Partial source index within the home globule |
| dst_code | input | SLOTS x 3 | Relative destination globule code |
| dst_reg | input | SLOTS x 4 | Destination register index in each target globule |
| res_data | input | SLOTS x DW | Result to write |
| rd_a | output | SLOTS x 6 | First operand read address |
| rd_b | output | SLOTS x 6 | Second operand read address |
| busy | output | 1 | Writes of the accepted bundle still pending |
| waw_flag | output | 4 | Per-globule same-register conflict pulse |
| wr_en | output | 4 | Per-globule write enable |
| wr_reg | output | 4 x 4 | Per-globule write register index |
| wr_data | output | 4 x DW | Per-globule write data |

## Verification
The bench goes after several corner cases.
- Modulo wraparound of the pair codes: home globule 3 with code 5 must reach globule 1. A design that does not wrap would write a wrong or missing globule.
- Three slots converging on one globule with different registers. A router without one-writer-per-globule arbitration would lose a value or reorder the writes.
- Two slots hitting one register. A design that keeps the lower slot leaves stale data, and the lower slot's write shows up as an unexpected write on the scoreboard.
- The cycle offset between home and remote writes, and the serialized broadcast under a one-port limit. A design that counts `busy` wrongly, or sends remote writes without the extra stage, is caught by cycle-exact samples.

// File: rtl/gwb_pkg.sv
package gwb_pkg;
  localparam int NGLOB  = 4;
  localparam int GIDX_W = 2;
  localparam int RIDX_W = 4;
  localparam int FULL_W = GIDX_W + RIDX_W;
  localparam int CODE_W = 3;

  typedef logic [NGLOB-1:0]  gmask_t;
  typedef logic [GIDX_W-1:0] gidx_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  function automatic gmask_t glob_bit(input gidx_t g);
    return gmask_t'(1) << g;
  endfunction

  // bit 2 clear: absolute unicast; bit 2 set: home plus offset, or all
  function automatic gmask_t expand_code(input logic [CODE_W-1:0] code, input gidx_t home);
    gidx_t k;
    k = code[1:0];
    if (!code[2]) return glob_bit(k);
    if (k == 2'b11) return '1;
    return glob_bit(home) | glob_bit(home + k + 2'd1);
  endfunction
endpackage

// File: rtl/gwb_expand.sv
module gwb_expand
  import gwb_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]              slot_vld,
  input  logic [SLOTS-1:0][FULL_W-1:0]  src_full,
  input  logic [SLOTS-1:0][RIDX_W-1:0]  src_part,
  input  logic [SLOTS-1:0][CODE_W-1:0]  dst_code,
  output logic [SLOTS-1:0][FULL_W-1:0]  rd_a,
  output logic [SLOTS-1:0][FULL_W-1:0]  rd_b,
  output logic [SLOTS-1:0][GIDX_W-1:0]  home,
  output logic [SLOTS-1:0][NGLOB-1:0]   mask
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign home[s] = src_full[s][FULL_W-1:RIDX_W];
    assign rd_a[s] = src_full[s];
    assign rd_b[s] = {home[s], src_part[s]};
    assign mask[s] = slot_vld[s] ? expand_code(dst_code[s], home[s]) : '0;
  end
endmodule

// File: rtl/gwb_waw.sv
module gwb_waw
  import gwb_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0][NGLOB-1:0]  mask,
  input  logic [SLOTS-1:0][RIDX_W-1:0] dst_reg,
  output logic [SLOTS-1:0][NGLOB-1:0]  keep,
  output logic [NGLOB-1:0]             waw
);
  // a later slot overrides an earlier one that targets the same register
  always_comb begin
    keep = mask;
    waw  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int t = s + 1; t < SLOTS; t++) begin
        for (int g = 0; g < NGLOB; g++) begin
          if (mask[s][g] && mask[t][g] && dst_reg[s] == dst_reg[t]) begin
            keep[s][g] = 1'b0;
            waw[g]     = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/gwb_sched.sv
module gwb_sched
  import gwb_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int WPORTS = 4,
  parameter int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0][NGLOB-1:0]  pend,
  input  logic [SLOTS-1:0][GIDX_W-1:0] home,
  input  logic [NGLOB-1:0]             rem_blk,
  output logic [SLOTS-1:0][NGLOB-1:0]  gnt,
  output logic [NGLOB-1:0]             g_vld,
  output logic [NGLOB-1:0]             g_far,
  output logic [NGLOB-1:0][SW-1:0]     g_slot
);
  always_comb begin
    int          used;
    logic        hit;
    logic        far;
    logic [SW-1:0] pick;
    used   = 0;
    gnt    = '0;
    g_vld  = '0;
    g_far  = '0;
    g_slot = '0;
    for (int g = 0; g < NGLOB; g++) begin
      hit  = 1'b0;
      pick = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
        if (pend[s][g]) begin
          hit  = 1'b1;
          pick = SW'(s);
        end
      end
      far = (home[pick] != GIDX_W'(g));
      // a home write may not land on a cycle already claimed by a remote one
      if (hit && used < WPORTS && (far || !rem_blk[g])) begin
        used          = used + 1;
        g_vld[g]      = 1'b1;
        g_far[g]      = far;
        g_slot[g]     = pick;
        gnt[pick][g]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gwb_router.sv
module gwb_router
  import gwb_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DW     = 32,
  parameter int WPORTS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [SLOTS-1:0]              slot_vld,
  input  logic [SLOTS-1:0][5:0]         src_full,
  input  logic [SLOTS-1:0][3:0]         src_part,
  input  logic [SLOTS-1:0][2:0]         dst_code,
  input  logic [SLOTS-1:0][3:0]         dst_reg,
  input  logic [SLOTS-1:0][DW-1:0]      res_data,
  output logic [SLOTS-1:0][5:0]         rd_a,
  output logic [SLOTS-1:0][5:0]         rd_b,
  output logic                          busy,
  output logic [3:0]                    waw_flag,
  output logic [3:0]                    wr_en,
  output logic [3:0][3:0]               wr_reg,
  output logic [3:0][DW-1:0]            wr_data
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0][GIDX_W-1:0] home;
  logic [SLOTS-1:0][NGLOB-1:0]  mask, keep, pend, gnt;
  logic [NGLOB-1:0]             waw, g_vld, g_far;
  logic [NGLOB-1:0][SW-1:0]     g_slot;
  logic                         accept;

  logic [SLOTS-1:0][GIDX_W-1:0] b_home;
  logic [SLOTS-1:0][RIDX_W-1:0] b_reg;
  logic [SLOTS-1:0][DW-1:0]     b_data;
  logic [NGLOB-1:0]             waw_q;

  logic [NGLOB-1:0]             loc_v, r1_v, r2_v;
  logic [NGLOB-1:0][RIDX_W-1:0] loc_reg, r1_reg, r2_reg;
  logic [NGLOB-1:0][DW-1:0]     loc_dat, r1_dat, r2_dat;

  gwb_expand #(.SLOTS(SLOTS)) u_exp (
    .slot_vld (slot_vld),
    .src_full (src_full),
    .src_part (src_part),
    .dst_code (dst_code),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .home     (home),
    .mask     (mask)
  );

  gwb_waw #(.SLOTS(SLOTS)) u_waw (
    .mask    (mask),
    .dst_reg (dst_reg),
    .keep    (keep),
    .waw     (waw)
  );

  gwb_sched #(.SLOTS(SLOTS), .WPORTS(WPORTS), .SW(SW)) u_sch (
    .pend    (pend),
    .home    (b_home),
    .rem_blk (r1_v),
    .gnt     (gnt),
    .g_vld   (g_vld),
    .g_far   (g_far),
    .g_slot  (g_slot)
  );

  assign busy     = |pend;
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign waw_flag = waw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      b_home <= '0;
      b_reg  <= '0;
      b_data <= '0;
      waw_q  <= '0;
    end else if (accept) begin
      pend   <= keep;
      b_home <= home;
      b_reg  <= dst_reg;
      b_data <= res_data;
      waw_q  <= waw;
    end else begin
      pend   <= pend & ~gnt;
      waw_q  <= '0;
    end
  end

  for (genvar g = 0; g < NGLOB; g++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loc_v[g]   <= 1'b0;
        r1_v[g]    <= 1'b0;
        r2_v[g]    <= 1'b0;
        loc_reg[g] <= '0;
        r1_reg[g]  <= '0;
        r2_reg[g]  <= '0;
        loc_dat[g] <= '0;
        r1_dat[g]  <= '0;
        r2_dat[g]  <= '0;
      end else begin
        loc_v[g]   <= g_vld[g] & ~g_far[g];
        r1_v[g]    <= g_vld[g] &  g_far[g];
        r2_v[g]    <= r1_v[g];
        loc_reg[g] <= b_reg[g_slot[g]];
        loc_dat[g] <= b_data[g_slot[g]];
        r1_reg[g]  <= b_reg[g_slot[g]];
        r1_dat[g]  <= b_data[g_slot[g]];
        r2_reg[g]  <= r1_reg[g];
        r2_dat[g]  <= r1_dat[g];
      end
    end
    assign wr_en[g]   = loc_v[g] | r2_v[g];
    assign wr_reg[g]  = loc_v[g] ? loc_reg[g] : r2_reg[g];
    assign wr_data[g] = loc_v[g] ? loc_dat[g] : r2_dat[g];
  end
endmodule

// File: rtl/gwb_router_chk.sv
module gwb_router_chk #(
  parameter int SLOTS  = 4,
  parameter int WPORTS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    busy,
  input logic [3:0]              waw_flag,
  input logic [SLOTS-1:0][3:0]   gnt,
  input logic [3:0]              loc_v,
  input logic [3:0]              far_v,
  input logic [SLOTS-1:0][3:0]   mask,
  input logic [SLOTS-1:0]        slot_vld
);
  logic [3:0][SLOTS-1:0] col;
  always_comb begin
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < SLOTS; s++)
        col[g][s] = gnt[s][g];
  end

  a_r9_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) <= WPORTS);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  a_r7_flag_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (waw_flag != 4'b0) |-> $past(in_valid && in_ready));

  for (genvar g = 0; g < 4; g++) begin : g_glob
    a_r8_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[g]));
    a_r6_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_v[g] && far_v[g]));
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    a_r3_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[s] |-> ($countones(mask[s]) == 1 || $countones(mask[s]) == 2
                       || $countones(mask[s]) == 4));
    a_r11_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[s] |-> (mask[s] == 4'b0));
  end
endmodule

bind gwb_router gwb_router_chk #(.SLOTS(SLOTS), .WPORTS(WPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .waw_flag (waw_flag),
  .gnt      (gnt),
  .loc_v    (loc_v),
  .far_v    (r2_v),
  .mask     (mask),
  .slot_vld (slot_vld)
);

// File: tb/sim_gwb_router.sv
module sim_gwb_router;
  localparam int S = 4;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic v0 = 1'b0, v1 = 1'b0;
  logic [S-1:0]         s_vld = '0;
  logic [S-1:0][5:0]    s_src = '0;
  logic [S-1:0][3:0]    s_part = '0;
  logic [S-1:0][2:0]    s_code = '0;
  logic [S-1:0][3:0]    s_reg = '0;
  logic [S-1:0][DW-1:0] s_dat = '0;

  logic rdy0, busy0, rdy1, busy1;
  logic [S-1:0][5:0] ra0, rb0, ra1, rb1;
  logic [3:0] waw0, waw1, we0, we1;
  logic [3:0][3:0] wr0, wr1;
  logic [3:0][DW-1:0] wd0, wd1;

  gwb_router #(.SLOTS(S), .DW(DW), .WPORTS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(rdy0),
    .slot_vld(s_vld), .src_full(s_src), .src_part(s_part), .dst_code(s_code),
    .dst_reg(s_reg), .res_data(s_dat), .rd_a(ra0), .rd_b(rb0), .busy(busy0),
    .waw_flag(waw0), .wr_en(we0), .wr_reg(wr0), .wr_data(wd0));

  gwb_router #(.SLOTS(S), .DW(DW), .WPORTS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1),
    .slot_vld(s_vld), .src_full(s_src), .src_part(s_part), .dst_code(s_code),
    .dst_reg(s_reg), .res_data(s_dat), .rd_a(ra1), .rd_b(rb1), .busy(busy1),
    .waw_flag(waw1), .wr_en(we1), .wr_reg(wr1), .wr_data(wd1));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] rf0 [4][16];
  logic [DW-1:0] rf1 [4][16];
  logic [2+4+DW-1:0] sb[$];
  int tfirst[4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference target set, written from R2-style rules independently
  function automatic logic [3:0] ref_tgt(logic [2:0] c, logic [1:0] x);
    logic [3:0] m;
    m = '0;
    if (c < 3'd4) m[c[1:0]] = 1'b1;
    else if (c == 3'd7) m = 4'hF;
    else begin
      m[x] = 1'b1;
      m[(int'(x) + int'(c) - 3) % 4] = 1'b1;
    end
    return m;
  endfunction

  // scoreboard monitor for u0, register model for u1
  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < 4; g++) begin
        if (we0[g]) begin
          int idx;
          idx = -1;
          rf0[g][wr0[g]] = wd0[g];
          for (int i = 0; i < sb.size(); i++)
            if (idx < 0 && sb[i][2+4+DW-1 -: 2] == 2'(g)) idx = i;
          checks++;
          if (idx < 0) begin
            errors++;
            $display("FAIL R2/R3/R4/R7/R11 unexpected write g%0d actual=%0h/%0h expected=none",
                     g, wr0[g], wd0[g]);
          end else begin
            if (sb[idx] !== {2'(g), wr0[g], wd0[g]}) begin
              errors++;
              $display("FAIL R2/R3/R4/R8 write g%0d actual=%0h expected=%0h",
                       g, {2'(g), wr0[g], wd0[g]}, sb[idx]);
            end
            sb.delete(idx);
          end
        end
        if (we1[g]) begin
          rf1[g][wr1[g]] = wd1[g];
          if (tfirst[g] < 0) tfirst[g] = cyc;
        end
      end
    end
  end

  task automatic slot(int s, logic vld, logic [5:0] src, logic [2:0] code,
                      logic [3:0] rg, logic [DW-1:0] d);
    s_vld[s] = vld; s_src[s] = src; s_code[s] = code; s_reg[s] = rg; s_dat[s] = d;
  endtask

  // driver: pushes expected writes, then offers the bundle until taken
  task automatic send(int inst);
    if (inst == 0) begin
      for (int g = 0; g < 4; g++)
        for (int s = 0; s < S; s++) begin
          bit lost;
          lost = 0;
          if (s_vld[s] && ref_tgt(s_code[s], s_src[s][5:4])[g]) begin
            for (int t = s + 1; t < S; t++)
              if (s_vld[t] && ref_tgt(s_code[t], s_src[t][5:4])[g] && s_reg[t] == s_reg[s])
                lost = 1;
            if (!lost) sb.push_back({2'(g), s_reg[s], s_dat[s]});
          end
        end
    end
    @(negedge clk);
    if (inst == 0) v0 = 1'b1; else v1 = 1'b1;
    while ((inst == 0) ? !rdy0 : !rdy1) @(negedge clk);
    @(posedge clk);
    #1;
    v0 = 1'b0; v1 = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy0 || busy1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int g = 0; g < 4; g++) tfirst[g] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset in_ready", rdy0, 1);
    chk("R10 reset busy", busy0, 0);
    chk("R10 reset wr_en", we0, 0);
    chk("R10 reset waw_flag", waw0, 0);

    // R1 read address forming
    for (int s = 0; s < S; s++) begin
      s_src[s] = {2'(s), 4'(s + 3)};
      s_part[s] = 4'(9 - s);
    end
    #1;
    for (int s = 0; s < S; s++) begin
      chk("R1 rd_a", ra0[s], {2'(s), 4'(s + 3)});
      chk("R1 rd_b", rb0[s], {2'(s), 4'(9 - s)});
    end

    // R5 / R6 home vs remote latency, home globule 1
    s_vld = '0;
    slot(0, 1, 6'h12, 3'd1, 4'd5, 32'hA0A0_0005);
    slot(1, 1, 6'h13, 3'd2, 4'd6, 32'hB0B0_0006);
    send(0);
    @(negedge clk); chk("R5 nothing before edge k+1", we0, 4'b0000);
    @(negedge clk); chk("R5 home write timing", we0, 4'b0010);
    chk("R5 home write reg", wr0[1], 5);
    @(negedge clk); chk("R6 remote write timing", we0, 4'b0100);
    drain();

    // R2 unicast codes from various homes
    s_vld = '0;
    slot(0, 1, 6'h30, 3'd0, 4'd1, 32'h0000_1111);
    slot(1, 1, 6'h00, 3'd3, 4'd2, 32'h0000_2222);
    slot(2, 0, 6'h10, 3'd1, 4'd9, 32'hDEAD_0000);
    slot(3, 1, 6'h20, 3'd2, 4'd4, 32'h0000_4444);
    send(0); drain();
    chk("R2 code0 to G0", rf0[0][1], 32'h0000_1111);
    chk("R2 code3 to G3", rf0[3][2], 32'h0000_2222);
    chk("R2 code2 to G2", rf0[2][4], 32'h0000_4444);

    // R3 pair codes with wraparound, three converging on G1
    s_vld = '0;
    slot(0, 1, 6'h10, 3'd4, 4'd7, 32'h7777_0001);
    slot(1, 1, 6'h30, 3'd5, 4'd8, 32'h8888_0003);
    slot(2, 1, 6'h20, 3'd6, 4'd9, 32'h9999_0002);
    send(0); drain();
    chk("R3 code4 home", rf0[1][7], 32'h7777_0001);
    chk("R3 code4 home+1", rf0[2][7], 32'h7777_0001);
    chk("R3 code5 home", rf0[3][8], 32'h8888_0003);
    chk("R3 code5 wrap", rf0[1][8], 32'h8888_0003);
    chk("R3 code6 home", rf0[2][9], 32'h9999_0002);
    chk("R3 code6 wrap", rf0[1][9], 32'h9999_0002);

    // R4 broadcast
    s_vld = '0;
    slot(0, 1, 6'h25, 3'd7, 4'hC, 32'hCAFE_000C);
    send(0); drain();
    for (int g = 0; g < 4; g++) chk("R4 broadcast", rf0[g][12], 32'hCAFE_000C);

    // R7 same register, higher slot wins
    s_vld = '0;
    slot(0, 1, 6'h10, 3'd1, 4'd3, 32'h0101_0000);
    slot(1, 1, 6'h10, 3'd1, 4'd4, 32'h0404_0000);
    slot(2, 1, 6'h10, 3'd1, 4'd3, 32'h0303_0002);
    send(0);
    @(negedge clk); chk("R7 waw flag", waw0, 4'b0010);
    @(negedge clk); chk("R7 waw flag pulse", waw0, 4'b0000);
    drain();
    chk("R7 later slot wins", rf0[1][3], 32'h0303_0002);
    chk("R7 other register kept", rf0[1][4], 32'h0404_0000);

    // R8 / R10 two writes to one globule, back-pressure timing
    s_vld = '0;
    slot(0, 1, 6'h20, 3'd2, 4'd1, 32'h5151_0001);
    slot(1, 1, 6'h20, 3'd2, 4'd2, 32'h5252_0002);
    send(0);
    @(negedge clk);
    chk("R10 busy while pending", busy0, 1);
    chk("R10 not ready while pending", rdy0, 0);
    @(negedge clk);
    chk("R8 lower slot first", {we0[2], wr0[2]}, {1'b1, 4'd1});
    chk("R10 busy second cycle", busy0, 1);
    @(negedge clk);
    chk("R8 upper slot next", {we0[2], wr0[2]}, {1'b1, 4'd2});
    chk("R10 ready again", rdy0, 1);
    drain();

    // R11 disabled slots
    s_vld = '0;
    slot(0, 0, 6'h00, 3'd7, 4'd0, 32'hBAD0_0000);
    slot(1, 0, 6'h10, 3'd1, 4'd0, 32'hBAD1_0000);
    s_vld = '0;
    send(0);
    @(negedge clk); chk("R11 no pending work", busy0, 0);
    drain();

    // R9 one write port per cycle on u1
    s_vld = '0;
    slot(0, 1, 6'h20, 3'd7, 4'd5, 32'hE5E5_0005);
    send(1);
    begin
      int n;
      n = 0;
      @(negedge clk);
      while (busy1 && n < 20) begin n++; @(negedge clk); end
      chk("R9 busy cycles", n, 4);
    end
    drain();
    for (int g = 0; g < 4; g++) chk("R9 serialized broadcast", rf1[g][5], 32'hE5E5_0005);
    chk("R9 G0 before G1", tfirst[0] < tfirst[1], 1);
    chk("R9 G1 before G3", tfirst[1] < tfirst[3], 1);

    chk("R2/R7 scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule